// File: doc/BRIEF.md
# Accumulator Operate Microcode Unit

This block carries out one operate microinstruction of the first group on a 12-bit accumulator paired with a one-bit link. The operations are clear, complement, increment, rotate and half-word swap. The caller presents the accumulator, the link and the eight microinstruction bits together with a valid strobe. One clock later the block returns the new accumulator and link with a one-cycle valid pulse.

The compile-time parameter `VARIANT` selects one of four historical behaviours. These differ in two ways: what happens when both rotate directions are requested at once, and whether complement and increment come before the rotate or give way to it. The first-stage ordering on the fuller variants is as follows: clear first, then complement, then increment, and rotate or swap last.

Top module: `opr_unit`

## Requirements
- R1: While `rst_ni` is low, `valid_o`, `ac_o` and `link_o` are all 0.
- R2: `valid_o` is high exactly in the cycle after a cycle with `valid_i` high. When `valid_i` is low, `ac_o` and `link_o` keep their previous values.
- R3: Microinstruction bit 7 clears the accumulator and bit 6 clears the link. After that, bit 5 complements the accumulator and bit 4 complements the link. For example, bits 7 and 5 together give all ones.
- R4: Bit 0 adds one to the accumulator after any complement. A carry out of bit 11 inverts the link.
- R5: Bit 2 rotates the 13-bit value {link, accumulator} left and bit 3 rotates it right. Each rotate moves one place, or two places when bit 1 is also set.
- R6: On variants 1, 2 and 3, the rotate acts on the value produced after clear, complement and increment.
- R7: Bit 1 with neither direction bit swaps the upper and lower 6-bit halves of the accumulator and leaves the link unchanged, on variants 2 and 3. On variants 0 and 1 it has no effect on the data.
- R8: Variant 1, both direction bits set: the block forms the left and right rotations of the same distance and returns their bitwise AND.
- R9: Variant 2, both direction bits set: no rotation happens, single or double. Clear, complement and increment still apply.
- R10: Variant 3, both direction bits set: with bit 1 clear, the result is the 13-bit value rotated left by three places. With bit 1 set, no rotation happens.
- R11: Variant 0, any direction bit set: the rotate acts on the value after clear only, and the complement and increment bits are discarded. With both direction bits set, that cleared value is returned unrotated.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Operands and microinstruction are present |
| uop_i | input | 8 | Microinstruction bits: 7 clear AC, 6 clear link, 5 complement AC, 4 complement link, 3 rotate right, 2 rotate left, 1 double/swap, 0 increment |
| ac_i | input | 12 | Accumulator before the instruction |
| link_i | input | 1 | Link before the instruction |
| valid_o | output | 1 | Result pulse, one cycle after valid_i |
| ac_o | output | 12 | Accumulator after the instruction |
| link_o | output | 1 | Link after the instruction |

## Verification
The block keeps only the result register, so any fault is visible on `ac_o` or `link_o` in the very cycle after the instruction that exposes it. A wrong stage order or a wrong variant branch shows as one or more wrong bits against the reference model at that point. A fault in the valid path shows as a missing or extra `valid_o` pulse, or as a result that changes while no instruction is presented. The bench runs all four variants side by side on the same directed and random instructions, so a fault confined to one variant's branch still produces a mismatch.

// File: rtl/opr_pkg.sv
`timescale 1ns/1ps
package opr_pkg;
  typedef enum logic [1:0] {
    VAR_EARLY  = 2'd0,
    VAR_ANDROT = 2'd1,
    VAR_NOPROT = 2'd2,
    VAR_TRIPLE = 2'd3
  } variant_e;

  localparam int UOP_W = 8;

  // field order matches the decoder's bit positions 7..0
  typedef struct packed {
    logic cla;
    logic cll;
    logic cma;
    logic cml;
    logic rar;
    logic ral;
    logic dbl;
    logic iac;
  } uop_t;

  function automatic logic has_swap(variant_e v);
    return (v == VAR_NOPROT) || (v == VAR_TRIPLE);
  endfunction
endpackage

// File: rtl/opr_prep.sv
`timescale 1ns/1ps
module opr_prep #(
  parameter int DW = 12
) (
  input  logic          cla_i,
  input  logic          cll_i,
  input  logic          cma_i,
  input  logic          cml_i,
  input  logic          iac_i,
  input  logic [DW-1:0] ac_i,
  input  logic          link_i,
  output logic [DW-1:0] clr_ac_o,
  output logic          clr_link_o,
  output logic [DW-1:0] mod_ac_o,
  output logic          mod_link_o
);
  logic [DW-1:0] cmp_ac;
  logic          cmp_link;
  logic [DW:0]   sum;

  always_comb begin
    clr_ac_o   = cla_i ? '0 : ac_i;
    clr_link_o = cll_i ? 1'b0 : link_i;
    cmp_ac     = cma_i ? ~clr_ac_o : clr_ac_o;
    cmp_link   = cml_i ? ~clr_link_o : clr_link_o;
    sum        = {1'b0, cmp_ac} + {{DW{1'b0}}, iac_i};
    mod_ac_o   = sum[DW-1:0];
    mod_link_o = cmp_link ^ sum[DW];
  end
endmodule

// File: rtl/opr_rotate.sv
`timescale 1ns/1ps
module opr_rotate #(
  parameter int                DW      = 12,
  parameter opr_pkg::variant_e VARIANT = opr_pkg::VAR_TRIPLE
) (
  input  logic          ral_i,
  input  logic          rar_i,
  input  logic          dbl_i,
  input  logic [DW-1:0] ac_i,
  input  logic          link_i,
  output logic [DW-1:0] ac_o,
  output logic          link_o
);
  localparam int W  = DW + 1;
  localparam int HW = DW / 2;

  logic [W-1:0] x, rl1, rl2, rl3, rr1, rr2, both_v, swap_v, res;

  assign x   = {link_i, ac_i};
  assign rl1 = {x[W-2:0], x[W-1]};
  assign rl2 = {x[W-3:0], x[W-1:W-2]};
  assign rl3 = {x[W-4:0], x[W-1:W-3]};
  assign rr1 = {x[0], x[W-1:1]};
  assign rr2 = {x[1:0], x[W-1:2]};

  generate
    if (VARIANT == opr_pkg::VAR_ANDROT) begin : g_both_and
      assign both_v = dbl_i ? (rl2 & rr2) : (rl1 & rr1);
    end else if (VARIANT == opr_pkg::VAR_TRIPLE) begin : g_both_r3
      assign both_v = dbl_i ? x : rl3;
    end else begin : g_both_nop
      assign both_v = x;
    end

    if (opr_pkg::has_swap(VARIANT)) begin : g_swap
      assign swap_v = {x[W-1], x[HW-1:0], x[DW-1:HW]};
    end else begin : g_noswap
      assign swap_v = x;
    end
  endgenerate

  always_comb begin
    unique case ({ral_i, rar_i})
      2'b10:   res = dbl_i ? rl2 : rl1;
      2'b01:   res = dbl_i ? rr2 : rr1;
      2'b11:   res = both_v;
      default: res = dbl_i ? swap_v : x;
    endcase
  end

  assign ac_o   = res[DW-1:0];
  assign link_o = res[W-1];
endmodule

// File: rtl/opr_unit.sv
`timescale 1ns/1ps
module opr_unit #(
  parameter int                DW      = 12,
  parameter opr_pkg::variant_e VARIANT = opr_pkg::VAR_TRIPLE
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic [opr_pkg::UOP_W-1:0] uop_i,
  input  logic [DW-1:0]            ac_i,
  input  logic                     link_i,
  output logic                     valid_o,
  output logic [DW-1:0]            ac_o,
  output logic                     link_o
);
  localparam bit EARLY = (VARIANT == opr_pkg::VAR_EARLY);

  opr_pkg::uop_t u;
  logic [DW-1:0] clr_ac, mod_ac, src_ac, rot_ac, fin_ac;
  logic          clr_lk, mod_lk, src_lk, rot_lk, fin_lk;
  logic          any_rot;

  assign u       = opr_pkg::uop_t'(uop_i);
  assign any_rot = u.ral | u.rar;

  opr_prep #(.DW(DW)) u_prep (
    .cla_i      (u.cla),
    .cll_i      (u.cll),
    .cma_i      (u.cma),
    .cml_i      (u.cml),
    .iac_i      (u.iac),
    .ac_i       (ac_i),
    .link_i     (link_i),
    .clr_ac_o   (clr_ac),
    .clr_link_o (clr_lk),
    .mod_ac_o   (mod_ac),
    .mod_link_o (mod_lk)
  );

  // earliest variant rotates the merely-cleared value
  assign src_ac = EARLY ? clr_ac : mod_ac;
  assign src_lk = EARLY ? clr_lk : mod_lk;

  opr_rotate #(.DW(DW), .VARIANT(VARIANT)) u_rot (
    .ral_i  (u.ral),
    .rar_i  (u.rar),
    .dbl_i  (u.dbl),
    .ac_i   (src_ac),
    .link_i (src_lk),
    .ac_o   (rot_ac),
    .link_o (rot_lk)
  );

  assign fin_ac = (EARLY && !any_rot) ? mod_ac : rot_ac;
  assign fin_lk = (EARLY && !any_rot) ? mod_lk : rot_lk;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      ac_o    <= '0;
      link_o  <= 1'b0;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        ac_o   <= fin_ac;
        link_o <= fin_lk;
      end
    end
  end
endmodule

// File: rtl/opr_unit_chk.sv
`timescale 1ns/1ps
module opr_unit_chk #(
  parameter int                DW      = 12,
  parameter opr_pkg::variant_e VARIANT = opr_pkg::VAR_TRIPLE
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      valid_i,
  input logic [opr_pkg::UOP_W-1:0] uop_i,
  input logic [DW-1:0]             ac_i,
  input logic                      link_i,
  input logic                      valid_o,
  input logic [DW-1:0]             ac_o,
  input logic                      link_o
);
  localparam int HW = DW / 2;

  always_comb begin
    if (!rst_ni) begin
      AST_RESET_CLEAR: assert (!valid_o && ac_o == '0 && !link_o); // R1
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R2
  AST_NO_SPURIOUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !valid_o); // R2
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> ($stable(ac_o) && $stable(link_o))); // R2
  AST_CLEAR_THEN_CMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && uop_i == 8'hF0) |=> (ac_o == {DW{1'b1}} && link_o)); // R3
  AST_INC_CARRY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && uop_i == 8'h01 && ac_i == {DW{1'b1}}) |=>
    (ac_o == '0 && link_o == !$past(link_i))); // R4
  AST_ROT_LEFT1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && uop_i == 8'h04) |=> ({link_o, ac_o} == {$past(ac_i), $past(link_i)})); // R5

  generate
    if (opr_pkg::has_swap(VARIANT)) begin : g_swap_chk
      AST_HALF_SWAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && uop_i == 8'h02) |=>
        (ac_o == {$past(ac_i[HW-1:0]), $past(ac_i[DW-1:HW])} && link_o == $past(link_i))); // R7
    end else begin : g_noswap_chk
      AST_SWAP_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (valid_i && uop_i == 8'h02) |=>
        (ac_o == $past(ac_i) && link_o == $past(link_i))); // R7
    end
  endgenerate
endmodule

bind opr_unit opr_unit_chk #(.DW(DW), .VARIANT(VARIANT)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .uop_i   (uop_i),
  .ac_i    (ac_i),
  .link_i  (link_i),
  .valid_o (valid_o),
  .ac_o    (ac_o),
  .link_o  (link_o)
);

// File: tb/sim_opr_unit.sv
`timescale 1ns/1ps
module sim_opr_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        vin = 1'b0;
  logic [7:0]  uop = 8'h00;
  logic [11:0] ac = 12'h000;
  logic        lk = 1'b0;

  logic        vo [4];
  logic [11:0] ao [4];
  logic        lo [4];

  int ev [4];
  int ea [4];
  int el [4];
  int total = 0;
  int bad = 0;
  bit finished = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  opr_unit #(.VARIANT(opr_pkg::VAR_TRIPLE)) u0 (.clk_i(clk), .rst_ni(rst_n), .valid_i(vin),
    .uop_i(uop), .ac_i(ac), .link_i(lk), .valid_o(vo[3]), .ac_o(ao[3]), .link_o(lo[3]));
  opr_unit #(.VARIANT(opr_pkg::VAR_NOPROT)) u1 (.clk_i(clk), .rst_ni(rst_n), .valid_i(vin),
    .uop_i(uop), .ac_i(ac), .link_i(lk), .valid_o(vo[2]), .ac_o(ao[2]), .link_o(lo[2]));
  opr_unit #(.VARIANT(opr_pkg::VAR_ANDROT)) u2 (.clk_i(clk), .rst_ni(rst_n), .valid_i(vin),
    .uop_i(uop), .ac_i(ac), .link_i(lk), .valid_o(vo[1]), .ac_o(ao[1]), .link_o(lo[1]));
  opr_unit #(.VARIANT(opr_pkg::VAR_EARLY)) u3 (.clk_i(clk), .rst_ni(rst_n), .valid_i(vin),
    .uop_i(uop), .ac_i(ac), .link_i(lk), .valid_o(vo[0]), .ac_o(ao[0]), .link_o(lo[0]));

  function automatic int rotl(int x, int n);
    return ((x << n) | (x >> (13 - n))) & 'h1fff;
  endfunction
  function automatic int rotr(int x, int n);
    return ((x >> n) | (x << (13 - n))) & 'h1fff;
  endfunction

  // returns {link, ac} as a 13-bit integer
  function automatic int model(int v, int u, int a_in, int l_in);
    int a, l, ca, cl, x, n;
    bit left, right, dbl;
    a = a_in; l = l_in;
    left = u[2]; right = u[3]; dbl = u[1];
    if (u[7]) a = 0;
    if (u[6]) l = 0;
    ca = a; cl = l;
    if (u[5]) a = a ^ 'hfff;
    if (u[4]) l = l ^ 1;
    if (u[0]) begin
      a = a + 1;
      if (a > 'hfff) begin a = a & 'hfff; l = l ^ 1; end
    end
    x = (l << 12) | a;
    if (v == 0 && (left || right)) x = (cl << 12) | ca;
    n = dbl ? 2 : 1;
    if (left && !right) x = rotl(x, n);
    else if (right && !left) x = rotr(x, n);
    else if (left && right) begin
      if (v == 1) x = rotl(x, n) & rotr(x, n);
      else if (v == 3 && !dbl) x = rotl(x, 3);
    end else if (dbl && v >= 2)
      x = (x & 'h1000) | ((x & 'h3f) << 6) | ((x >> 6) & 'h3f);
    return x;
  endfunction

  task automatic cmp(int d, string what, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s variant%0d %s actual=%0h expected=%0h", tag, d, what, act, exp);
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    for (int d = 0; d < 4; d++) begin
      if (!rst_n) begin
        ev[d] = 0; ea[d] = 0; el[d] = 0;
      end else begin
        ev[d] = vin;
        if (vin) begin
          int r;
          r = model(d, uop, ac, lk);
          ea[d] = r & 'hfff;
          el[d] = (r >> 12) & 1;
        end
      end
    end
    #1;
    for (int d = 0; d < 4; d++) begin
      cmp(d, "valid", vo[d], ev[d]);
      cmp(d, "ac", ao[d], ea[d]);
      cmp(d, "link", lo[d], el[d]);
    end
  end

  task automatic step(string t, bit v, int u, int a, int l);
    @(negedge clk);
    tag = t; vin = v; uop = u[7:0]; ac = a[11:0]; lk = l[0];
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    total++;
    if (vo[3] !== 1'b0 || ao[3] !== 12'h0 || lo[3] !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset actual=%0b/%0h/%0b expected=0/0/0", vo[3], ao[3], lo[3]);
    end
    rst_n = 1'b1;
    step("R2", 1, 'h00, 'h9c3, 1);
    step("R2", 0, 'h80, 'h111, 0);
    step("R2", 0, 'h80, 'h222, 1);
    step("R3", 1, 'hA0, 'h123, 0);
    step("R3", 1, 'hF0, 'h5a5, 0);
    step("R3", 1, 'h50, 'h5a5, 1);
    step("R4", 1, 'h01, 'hfff, 0);
    step("R4", 1, 'h21, 'h000, 1);
    step("R4", 1, 'h01, 'h7ff, 1);
    step("R5", 1, 'h04, 'h801, 1);
    step("R5", 1, 'h08, 'h801, 1);
    step("R5", 1, 'h06, 'h801, 0);
    step("R5", 1, 'h0A, 'h803, 1);
    step("R6", 1, 'h05, 'hfff, 0);
    step("R6", 1, 'h29, 'h0f0, 1);
    step("R7", 1, 'h02, 'h03f, 1);
    step("R7", 1, 'h02, 'ha5c, 0);
    step("R8", 1, 'h0C, 'h5a3, 1);
    step("R8", 1, 'h0E, 'h7e1, 0);
    step("R9", 1, 'h2C, 'h5a3, 0);
    step("R9", 1, 'h0E, 'h5a3, 1);
    step("R10", 1, 'h0C, 'h801, 1);
    step("R10", 1, 'h0E, 'h801, 1);
    step("R11", 1, 'h25, 'h0f0, 0);
    step("R11", 1, 'h9C, 'h3c3, 1);
    step("R11", 1, 'h11, 'h00f, 0);
    for (int i = 0; i < 600; i++) begin
      step("R2", $urandom_range(0, 3) != 0, $urandom_range(0, 255),
           $urandom_range(0, 4095), $urandom_range(0, 1));
    end
    step("R2", 0, 0, 0, 0);
    @(negedge clk);
    finish_run();
  end
endmodule